// File: doc/BRIEF.md
# One-Time-Programmable ROM Program/Verify Sequencer

This block drives the control pins of a device programmer that burns a one-time-programmable on-chip ROM one word at a time. For every word it runs a fixed chain of pin actions, each held for a programmable number of sequencer clocks. It selects program mode and raises the access pin to its programming level. It then puts the word address on the data bus and the upper address port, latches the address with a reset rising edge, swaps the bus over to the word data, and enables the programming supply. A single long program pulse follows. After the pulse it drops the supply, releases the bus, enters verify mode and compares the byte the device drives back with the intended data.

A run starts at word address zero and ends at a programmable last address. It stops early on the first read-back mismatch. The device's free-running address-latch-enable clock is watched throughout. If that clock is missing, a run cannot start. If it stops during a run, the sequence aborts and every supply and mode enable falls back to its safe idle level. The high-voltage switching itself lies outside the block, which only drives digital enables.

Top module: `otp_prog_seq`

## Requirements
- R1: Outside a run (after reset, on completion, on failure or abort) the outputs sit at idle: test-mode pin high, access-pin high level off, device reset low, bus not driven, programming supply off, program pulse low.
- R2: Each word is sequenced in this order. The test-mode pin goes low, then the access pin rises (first word only), then the address is driven, then the device reset rises, then the bus carries data, then the supply is enabled, then the pulse starts. Each step holds for at least SETUP_CYC clocks before the next one.
- R3: The program pulse lasts exactly PULSE_CYC clocks. Throughout it the supply is enabled, device reset is high, the test-mode pin is low, the access pin is at programming level and the data stays driven.
- R4: After the pulse, the supply turns off while the data is still driven. Then the test-mode pin rises with the bus released. After SETUP_CYC clocks the read-back byte is compared. The test-mode pin then falls, device reset then falls, and the next word starts at the address step.
- R5: During the address step, bus_o carries address bits [7:0] and addr_hi_o carries bits [10:8]. addr_hi_o keeps its value through the data step. Words are processed from 0 up to end_addr_i inclusive, and word_ok_o pulses for one clock per word that verifies.
- R6: On the first verify mismatch the run stops at once with no further pulse. fail_o is set and word_addr_o holds the failing address.
- R7: A start request is ignored unless a rising edge of ale_i was seen within the last ALE_TIMEOUT clocks.
- R8: After the last word verifies, done_o is set and the outputs return to idle.
- R9: If ale_i shows no rising edge for ALE_TIMEOUT clocks during a run, the run aborts within a few clocks, abort_o is set and all enables go to idle, even in the middle of a pulse.
- R10: An accepted start clears done_o, fail_o and abort_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a programming run |
| end_addr_i | input | ADDR_W | Last word address, sampled on start |
| wr_data_i | input | BUS_W | Data for the word at word_addr_o |
| rd_data_i | input | BUS_W | Byte read back from the device bus |
| ale_i | input | 1 | Device address-latch-enable clock |
| tst0_o | output | 1 | Test-mode pin level (0 program, 1 verify/idle) |
| ea_hv_o | output | 1 | Enable for access-pin programming level |
| dev_rst_o | output | 1 | Device reset pin level |
| vdd_hv_o | output | 1 | Enable for programming supply |
| prog_o | output | 1 | Program pulse enable |
| bus_oe_o | output | 1 | Drive enable for the data bus |
| bus_o | output | BUS_W | Value driven on the data bus |
| addr_hi_o | output | HI_W | Upper address bits on the port |
| word_addr_o | output | ADDR_W | Current word address |
| busy_o | output | 1 | Run in progress |
| word_ok_o | output | 1 | One-clock pulse per verified word |
| done_o | output | 1 | Run completed (sticky) |
| fail_o | output | 1 | Verify mismatch (sticky) |
| abort_o | output | 1 | Latch clock lost (sticky) |

## Verification
A corrupt state register shows at once on the pin enables. It would show as a supply enabled outside a pulse window, as the bus driven while in verify mode, or as a pulse with reset low. Each of these breaks a pin-relation property on the very next clock. A wrong timer load shows as a wrong pulse length or step spacing, which the bench measures once per word. A wrong address counter shows as bytes landing at the wrong place in the bench's device model. A dead clock monitor shows as a run that never aborts within ALE_TIMEOUT plus a few clocks.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_T0LO, S_EAHI, S_ADDR, S_RSTHI, S_DATA, S_VDDHI,
    S_PULSE, S_VDDLO, S_VERIFY, S_T0DN, S_RSTLO
  } seq_state_e;

  typedef struct packed {
    logic tst0;
    logic ea_hv;
    logic dev_rst;
    logic bus_oe;
    logic vdd_hv;
    logic prog;
    logic drv_addr;
    logic drv_data;
  } pin_ctl_t;

  function automatic pin_ctl_t pin_decode(seq_state_e s);
    pin_ctl_t p;
    p = '{tst0: 1'b1, default: 1'b0};
    case (s)
      S_T0LO:   p.tst0 = 1'b0;
      S_EAHI:   begin p.tst0 = 1'b0; p.ea_hv = 1'b1; end
      S_ADDR:   begin p.tst0 = 1'b0; p.ea_hv = 1'b1; p.bus_oe = 1'b1; p.drv_addr = 1'b1; end
      S_RSTHI:  begin p.tst0 = 1'b0; p.ea_hv = 1'b1; p.bus_oe = 1'b1; p.drv_addr = 1'b1;
                      p.dev_rst = 1'b1; end
      S_DATA:   begin p.tst0 = 1'b0; p.ea_hv = 1'b1; p.bus_oe = 1'b1; p.drv_data = 1'b1;
                      p.dev_rst = 1'b1; end
      S_VDDHI:  begin p.tst0 = 1'b0; p.ea_hv = 1'b1; p.bus_oe = 1'b1; p.drv_data = 1'b1;
                      p.dev_rst = 1'b1; p.vdd_hv = 1'b1; end
      S_PULSE:  begin p.tst0 = 1'b0; p.ea_hv = 1'b1; p.bus_oe = 1'b1; p.drv_data = 1'b1;
                      p.dev_rst = 1'b1; p.vdd_hv = 1'b1; p.prog = 1'b1; end
      S_VDDLO:  begin p.tst0 = 1'b0; p.ea_hv = 1'b1; p.bus_oe = 1'b1; p.drv_data = 1'b1;
                      p.dev_rst = 1'b1; end
      S_VERIFY: begin p.ea_hv = 1'b1; p.dev_rst = 1'b1; end
      S_T0DN:   begin p.tst0 = 1'b0; p.ea_hv = 1'b1; p.dev_rst = 1'b1; end
      S_RSTLO:  begin p.tst0 = 1'b0; p.ea_hv = 1'b1; end
      default:  p = '{tst0: 1'b1, default: 1'b0};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ale_monitor.sv
module ale_monitor #(
  parameter int TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ale_i,
  output logic alive_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic [2:0]       sync_q;
  logic             seen_q;
  logic [CNT_W-1:0] gap_q;
  logic             rise;

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], ale_i};
      if (rise) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else if (gap_q != LIMIT) begin
        gap_q  <= gap_q + CNT_W'(1);
      end
    end
  end

  assign alive_o = seen_q && (gap_q < LIMIT);
endmodule

// File: rtl/word_addr_ctr.sv
module word_addr_ctr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      end_q  <= '0;
    end else if (clr_i) begin
      addr_q <= '0;
      end_q  <= end_addr_i;
    end else if (inc_i) begin
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == end_q);
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_seq_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int HI_W        = 3,
  parameter int SETUP_CYC   = 16,
  parameter int PULSE_CYC   = 50000,
  parameter int ALE_TIMEOUT = 64,
  localparam int ADDR_W     = BUS_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic [BUS_W-1:0]  rd_data_i,
  input  logic              ale_i,
  output logic              tst0_o,
  output logic              ea_hv_o,
  output logic              dev_rst_o,
  output logic              vdd_hv_o,
  output logic              prog_o,
  output logic              bus_oe_o,
  output logic [BUS_W-1:0]  bus_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic              busy_o,
  output logic              word_ok_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              abort_o
);
  localparam int MAX_LEN = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] PULSE_LEN = CNT_W'(PULSE_CYC);
  localparam logic [CNT_W-1:0] STEP_LEN  = CNT_W'(SETUP_CYC);

  seq_state_e        state_q, state_d;
  pin_ctl_t          pins;
  logic              alive, tmr_done, tmr_load, last_word;
  logic              clr, inc, set_done, set_fail, set_abort, ok_d;
  logic [CNT_W-1:0]  tmr_len;
  logic [ADDR_W-1:0] addr;

  seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .len_i(tmr_len), .done_o(tmr_done)
  );

  ale_monitor #(.TIMEOUT(ALE_TIMEOUT)) u_ale (
    .clk_i, .rst_ni, .ale_i, .alive_o(alive)
  );

  word_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(inc), .end_addr_i,
    .addr_o(addr), .last_o(last_word)
  );

  always_comb begin
    state_d   = state_q;
    clr       = 1'b0;
    inc       = 1'b0;
    set_done  = 1'b0;
    set_fail  = 1'b0;
    set_abort = 1'b0;
    ok_d      = 1'b0;
    if (state_q == S_IDLE) begin
      if (start_i && alive) begin
        state_d = S_T0LO;
        clr     = 1'b1;
      end
    end else if (!alive) begin
      state_d   = S_IDLE;
      set_abort = 1'b1;
    end else if (tmr_done) begin
      case (state_q)
        S_T0LO:   state_d = S_EAHI;
        S_EAHI:   state_d = S_ADDR;
        S_ADDR:   state_d = S_RSTHI;
        S_RSTHI:  state_d = S_DATA;
        S_DATA:   state_d = S_VDDHI;
        S_VDDHI:  state_d = S_PULSE;
        S_PULSE:  state_d = S_VDDLO;
        S_VDDLO:  state_d = S_VERIFY;
        S_VERIFY: begin
          if (rd_data_i != wr_data_i) begin
            state_d  = S_IDLE;
            set_fail = 1'b1;
          end else begin
            state_d  = S_T0DN;
            ok_d     = 1'b1;
          end
        end
        S_T0DN:   state_d = S_RSTLO;
        S_RSTLO: begin
          if (last_word) begin
            state_d  = S_IDLE;
            set_done = 1'b1;
          end else begin
            state_d  = S_ADDR;
            inc      = 1'b1;
          end
        end
        default:  state_d = S_IDLE;
      endcase
    end
  end

  assign tmr_load = (state_d != state_q) && (state_d != S_IDLE);
  assign tmr_len  = (state_d == S_PULSE) ? PULSE_LEN : STEP_LEN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      done_o    <= 1'b0;
      fail_o    <= 1'b0;
      abort_o   <= 1'b0;
      word_ok_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      word_ok_o <= ok_d;
      if (clr) begin
        done_o  <= 1'b0;
        fail_o  <= 1'b0;
        abort_o <= 1'b0;
      end else begin
        if (set_done)  done_o  <= 1'b1;
        if (set_fail)  fail_o  <= 1'b1;
        if (set_abort) abort_o <= 1'b1;
      end
    end
  end

  assign pins        = pin_decode(state_q);
  assign tst0_o      = pins.tst0;
  assign ea_hv_o     = pins.ea_hv;
  assign dev_rst_o   = pins.dev_rst;
  assign vdd_hv_o    = pins.vdd_hv;
  assign prog_o      = pins.prog;
  assign bus_oe_o    = pins.bus_oe;
  assign bus_o       = pins.drv_addr ? addr[BUS_W-1:0] :
                       pins.drv_data ? wr_data_i : '0;
  assign addr_hi_o   = (pins.drv_addr | pins.drv_data) ? addr[ADDR_W-1:BUS_W] : '0;
  assign word_addr_o = addr;
  assign busy_o      = (state_q != S_IDLE);
endmodule

// File: rtl/otp_seq_chk.sv
module otp_seq_chk #(
  parameter int PULSE_CYC = 50000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tst0_o,
  input logic ea_hv_o,
  input logic dev_rst_o,
  input logic vdd_hv_o,
  input logic prog_o,
  input logic bus_oe_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o,
  input logic abort_o
);
  int unsigned pw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pw_q <= 0;
    else if (prog_o) pw_q <= pw_q + 1;
    else             pw_q <= 0;
  end

  // R1
  idle_levels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (tst0_o && !ea_hv_o && !dev_rst_o && !vdd_hv_o && !prog_o && !bus_oe_o));

  // R3
  pulse_ctx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> (vdd_hv_o && dev_rst_o && !tst0_o && ea_hv_o && bus_oe_o));

  // R3
  pulse_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_q <= PULSE_CYC);

  // R3
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(prog_o) && !abort_o) |-> (pw_q == PULSE_CYC));

  // R2
  supply_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vdd_hv_o) |-> (dev_rst_o && ea_hv_o && !tst0_o && bus_oe_o));

  // R4
  verify_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tst0_o && busy_o) |-> (!bus_oe_o && !vdd_hv_o && dev_rst_o));

  // R6
  fail_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> !busy_o);

  // R8
  done_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !busy_o);

  // R9
  abort_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> (!busy_o && !vdd_hv_o && !prog_o));
endmodule

bind otp_prog_seq otp_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tst0_o(tst0_o), .ea_hv_o(ea_hv_o),
  .dev_rst_o(dev_rst_o), .vdd_hv_o(vdd_hv_o), .prog_o(prog_o),
  .bus_oe_o(bus_oe_o), .busy_o(busy_o), .done_o(done_o),
  .fail_o(fail_o), .abort_o(abort_o)
);

// File: tb/tb_otp_prog_seq.sv
module tb_otp_prog_seq;
  localparam int CLK_P   = 10;
  localparam int BUS_W   = 8;
  localparam int HI_W    = 3;
  localparam int ADDR_W  = BUS_W + HI_W;
  localparam int SETUP   = 4;
  localparam int PULSE   = 40;
  localparam int TMO     = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [ADDR_W-1:0] end_addr = '0;
  logic [BUS_W-1:0]  wr_data, rd_data, bus;
  logic [HI_W-1:0]   addr_hi;
  logic [ADDR_W-1:0] word_addr;
  logic tst0, ea_hv, dev_rst, vdd_hv, prog, bus_oe, busy, word_ok, done, fail, abort_f;
  logic ale = 1'b0, ale_en = 1'b0;
  logic bad_en = 1'b0;
  logic [ADDR_W-1:0] bad_addr = '0;

  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  otp_prog_seq #(.BUS_W(BUS_W), .HI_W(HI_W), .SETUP_CYC(SETUP),
                 .PULSE_CYC(PULSE), .ALE_TIMEOUT(TMO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .end_addr_i(end_addr),
    .wr_data_i(wr_data), .rd_data_i(rd_data), .ale_i(ale),
    .tst0_o(tst0), .ea_hv_o(ea_hv), .dev_rst_o(dev_rst), .vdd_hv_o(vdd_hv),
    .prog_o(prog), .bus_oe_o(bus_oe), .bus_o(bus), .addr_hi_o(addr_hi),
    .word_addr_o(word_addr), .busy_o(busy), .word_ok_o(word_ok),
    .done_o(done), .fail_o(fail), .abort_o(abort_f)
  );

  function automatic logic [BUS_W-1:0] pat(logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[10:8], 5'b0} ^ 8'h3C;
  endfunction

  assign wr_data = pat(word_addr);

  // device model
  logic [BUS_W-1:0]  mem [1<<ADDR_W];
  logic [ADDR_W-1:0] lat = '0;
  int ale_div = 0;
  assign rd_data = (tst0 && dev_rst) ?
                   (mem[lat] ^ ((bad_en && lat == bad_addr) ? 8'h10 : 8'h00)) : 8'hFF;

  always @(posedge clk) begin
    if (ale_en) begin
      if (ale_div == 2) begin ale_div <= 0; ale <= ~ale; end
      else ale_div <= ale_div + 1;
    end
  end

  // pin monitor
  int cyc = 0, pulses = 0, oks = 0, order_err = 0, gap_err = 0, width_err = 0;
  int t_t0fall = 0, t_rst = 0, t_vdd = 0, t_prog = 0, t_progfall = 0;
  logic p_tst0 = 1'b1, p_ea = 1'b0, p_rst = 1'b0, p_vdd = 1'b0, p_prog = 1'b0;

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    p_tst0 <= tst0; p_ea <= ea_hv; p_rst <= dev_rst; p_vdd <= vdd_hv; p_prog <= prog;
    if (word_ok) oks <= oks + 1;
    if (p_tst0 && !tst0) t_t0fall <= cyc;
    if (!p_ea && ea_hv && (cyc - t_t0fall < SETUP)) gap_err <= gap_err + 1;
    if (!p_rst && dev_rst) begin
      lat   <= {addr_hi, bus};
      t_rst <= cyc;
      if (!bus_oe || !ea_hv || tst0) order_err <= order_err + 1;
    end
    if (!p_vdd && vdd_hv) begin
      t_vdd <= cyc;
      if (cyc - t_rst < 2*SETUP) gap_err <= gap_err + 1;
    end
    if (!p_prog && prog) begin
      pulses <= pulses + 1;
      t_prog <= cyc;
      mem[lat] <= bus;
      if (cyc - t_vdd < SETUP) gap_err <= gap_err + 1;
      if (!vdd_hv || !dev_rst || tst0 || !ea_hv) order_err <= order_err + 1;
    end
    if (p_prog && !prog) begin
      t_progfall <= cyc;
      if (!abort_f && (cyc - t_prog != PULSE)) width_err <= width_err + 1;
    end
    if (!p_tst0 && tst0 && busy) begin
      if (vdd_hv || bus_oe || (cyc - t_progfall < SETUP)) order_err <= order_err + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(tst0 && !ea_hv && !dev_rst && !bus_oe && !vdd_hv && !prog && !busy, req,
          {tst0, ea_hv, dev_rst, bus_oe, vdd_hv, prog, busy}, 7'b1000000);
  endtask

  task automatic run(input int last);
    @(negedge clk);
    end_addr = ADDR_W'(last);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check_idle("R1");
    check(!done && !fail && !abort_f, "R1", {done, fail, abort_f}, 0);
  endtask

  task automatic t_blocked;
    run(2);
    repeat (5) @(negedge clk);
    check(!busy && tst0, "R7", busy, 0);
    check(pulses == 0, "R7", pulses, 0);
  endtask

  task automatic t_normal;
    int p0, k0;
    ale_en = 1'b1;
    repeat (20) @(negedge clk);
    p0 = pulses; k0 = oks;
    run(5);
    wait_idle(20000);
    check(done && !fail && !abort_f, "R8", {done, fail, abort_f}, 3'b100);
    check_idle("R8");
    check(pulses - p0 == 6, "R5", pulses - p0, 6);
    check(oks - k0 == 6, "R5", oks - k0, 6);
    for (int a = 0; a <= 5; a++)
      check(mem[a] == pat(ADDR_W'(a)), "R5", mem[a], pat(ADDR_W'(a)));
    check(mem[6] == 8'hFF, "R5", mem[6], 8'hFF);
    check(width_err == 0, "R3", width_err, 0);
    check(order_err == 0, "R4", order_err, 0);
    check(gap_err == 0, "R2", gap_err, 0);
  endtask

  task automatic t_single;
    int p0;
    p0 = pulses;
    run(0);
    wait_idle(20000);
    check(done && pulses - p0 == 1, "R5", pulses - p0, 1);
  endtask

  task automatic t_high_addr;
    run(257);
    wait_idle(60000);
    check(done, "R8", done, 1);
    check(mem[256] == pat(11'd256), "R5", mem[256], pat(11'd256));
    check(mem[257] == pat(11'd257), "R5", mem[257], pat(11'd257));
    check(mem[258] == 8'hFF, "R5", mem[258], 8'hFF);
    check(width_err == 0 && order_err == 0 && gap_err == 0, "R2",
          width_err + order_err + gap_err, 0);
  endtask

  task automatic t_mismatch;
    int p0, k0;
    bad_en = 1'b1; bad_addr = 11'd3;
    p0 = pulses; k0 = oks;
    run(6);
    wait_idle(20000);
    check(fail && !done, "R6", {fail, done}, 2'b10);
    check(int'(word_addr) == 3, "R6", word_addr, 3);
    check(pulses - p0 == 4, "R6", pulses - p0, 4);
    check(oks - k0 == 3, "R6", oks - k0, 3);
    check_idle("R6");
    repeat (50) @(negedge clk);
    check(pulses - p0 == 4, "R6", pulses - p0, 4);
    bad_en = 1'b0;
  endtask

  task automatic t_restart_clears;
    run(1);
    @(negedge clk);
    check(busy && !fail, "R10", {busy, fail}, 2'b10);
    wait_idle(20000);
    check(done && !fail, "R10", {done, fail}, 2'b10);
  endtask

  task automatic t_abort;
    int p0;
    p0 = pulses;
    run(20);
    for (int i = 0; i < 20000 && pulses - p0 < 3; i++) @(negedge clk);
    for (int i = 0; i < 20000 && !prog; i++) @(negedge clk);
    ale_en = 1'b0;
    repeat (TMO + 12) @(negedge clk);
    check(abort_f && !done, "R9", {abort_f, done}, 2'b10);
    check_idle("R9");
    repeat (10) @(negedge clk);
    run(1);
    repeat (5) @(negedge clk);
    check(!busy, "R7", busy, 0);
    ale_en = 1'b1;
    repeat (20) @(negedge clk);
    run(1);
    wait_idle(20000);
    check(done && !abort_f, "R10", {done, abort_f}, 2'b10);
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_blocked();
    t_normal();
    t_single();
    t_mismatch();
    t_restart_clears();
    t_high_addr();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule